// File: doc/BRIEF.md
# Inline Deduplication Lookup Engine

The engine sits in a storage write path and decides, chunk by chunk, whether incoming data is already stored. The write stream arrives as 32-bit words over a valid/ready handshake. Each run of `CHUNK_WORDS` accepted words forms one chunk, and the default of 1024 words is a 4 KB chunk. While the words stream in, a CRC-32 digest is built up over the chunk. After the last word, the digest is looked up in a direct-mapped table whose slot is chosen by the low digest bits.

There are three possible outcomes:
- **Digest found.** The chunk is a duplicate. The stored reference count rises, and no storage node is selected.
- **Slot empty.** The digest is installed with a count of one.
- **Slot held by another digest.** The chunk is still treated as new and the resident entry is kept, with an overflow flag raised.

A new chunk is sent to storage node `digest mod NODES`, so placement follows content and spreads evenly. Each chunk yields exactly one result pulse. The pulse carries:
- the duplicate/new decision;
- the slot index;
- the reference count;
- the target node;
- the digest;
- a one-hot node-select vector.

Top module: `dedup_engine`

## Requirements
- R1: A chunk is exactly `CHUNK_WORDS` words accepted (in_valid and in_ready both high at a clock edge). For the edge that accepts the last word, call it E:
  - in_ready is low for the one cycle after E;
  - res_valid is high for exactly one cycle, the one after edge E+1;
  - exactly one result is produced per chunk.
- R2: res_digest is the CRC-32 of the chunk, computed as follows:
  - polynomial 0x04C11DB7;
  - register preset to 0xFFFFFFFF;
  - each word shifted in most significant bit first, in arrival order;
  - no bit reflection and no final inversion.
- R3: res_index equals the low `IDX_W` bits of the digest, which select the table slot.
- R4: A chunk whose digest equals the digest stored in its valid slot gives res_dup=1, and its reference count is incremented and reported on res_refcnt.
- R5: For a duplicate, node_sel is all zero, so no data write is issued.
- R6: A chunk whose slot is empty gives the following:
  - res_dup=0 and res_refcnt=1;
  - res_node = digest mod `NODES`;
  - node_sel has exactly bit res_node set;
  - the digest is stored in the slot.
- R7: The reference count saturates at 2^`REF_W`-1 and never wraps.
- R8: A chunk whose slot holds a different digest gives the following:
  - res_dup=0, res_overflow=1 and res_refcnt=0;
  - it is still routed to node digest mod `NODES`;
  - the resident entry and its count are left unchanged.
- R9: After reset, in_ready=1, res_valid=0, node_sel=0, and the table is empty.
- R10: Idle cycles with in_valid low, placed between the words of a chunk, do not change the digest or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Engine can accept a word |
| in_data | input | 32 | Chunk data word |
| res_valid | output | 1 | One-cycle result pulse per chunk |
| res_dup | output | 1 | Chunk is a duplicate |
| res_overflow | output | 1 | Slot was occupied by another digest |
| res_index | output | IDX_W | Table slot of the chunk |
| res_refcnt | output | REF_W | Reference count after the update (0 on overflow) |
| res_node | output | NODE_W | Target node, digest mod NODES |
| res_digest | output | 32 | CRC-32 digest of the chunk |
| node_sel | output | NODES | One-hot node write select, pulsed with a new chunk |

## Verification
The bench runs the main lookup with several kinds of traffic, and each kind isolates one decision path:
- **Distinct chunks into empty slots** exercise the digest, the modulo placement over a three-node configuration, and the install path.
- **Repeats of a stored chunk** exercise the reference-count path and the suppression of node selection.
- **A chunk replayed many times** drives the count into saturation.
- **A chunk sent with idle gaps between its words** confirms that stalls leave the digest untouched.
- **A chunk found by search to share a slot with a stored one but not its digest** exercises the overflow path. Resending the stored chunk afterwards proves the resident entry survived.

// File: rtl/dedup_pkg.sv
package dedup_pkg;

    localparam int DIGEST_W = 32;
    localparam logic [DIGEST_W-1:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [DIGEST_W-1:0] CRC_SEED = 32'hFFFF_FFFF;

    typedef enum logic {
        ST_ACCUM  = 1'b0,
        ST_LOOKUP = 1'b1
    } eng_state_e;

    // Shift one 32-bit word into the CRC register, MSB first.
    function automatic logic [DIGEST_W-1:0] crc_word(
        input logic [DIGEST_W-1:0] crc_in,
        input logic [DIGEST_W-1:0] word
    );
        logic [DIGEST_W-1:0] c;
        logic fb;
        c = crc_in;
        for (int b = DIGEST_W - 1; b >= 0; b--) begin
            fb = c[DIGEST_W-1] ^ word[b];
            c  = {c[DIGEST_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/dedup_crc_acc.sv
module dedup_crc_acc
    import dedup_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take,
    input  logic                first,
    input  logic [DIGEST_W-1:0] word,
    output logic [DIGEST_W-1:0] crc_next
);

    logic [DIGEST_W-1:0] crc_d, crc_q;

    always_comb begin
        crc_next = crc_word(first ? CRC_SEED : crc_q, word);
        crc_d    = take ? crc_next : crc_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= CRC_SEED;
        else        crc_q <= crc_d;
    end

endmodule

// File: rtl/dedup_table.sv
module dedup_table
    import dedup_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int REF_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lookup_en,
    input  logic [DIGEST_W-1:0] digest,
    output logic                hit,
    output logic                collide,
    output logic [REF_W-1:0]    ref_after
);

    localparam int ENTRIES = 1 << IDX_W;
    localparam logic [REF_W-1:0] REF_MAX = {REF_W{1'b1}};

    logic                valid_d [ENTRIES];
    logic                valid_q [ENTRIES];
    logic [DIGEST_W-1:0] tag_d   [ENTRIES];
    logic [DIGEST_W-1:0] tag_q   [ENTRIES];
    logic [REF_W-1:0]    ref_d   [ENTRIES];
    logic [REF_W-1:0]    ref_q   [ENTRIES];

    logic [IDX_W-1:0] idx;

    always_comb begin
        idx     = digest[IDX_W-1:0];
        hit     = valid_q[idx] && (tag_q[idx] == digest);
        collide = valid_q[idx] && !hit;
        if (hit)
            ref_after = (ref_q[idx] == REF_MAX) ? REF_MAX : ref_q[idx] + 1'b1;
        else if (collide)
            ref_after = '0;
        else
            ref_after = REF_W'(1);

        valid_d = valid_q;
        tag_d   = tag_q;
        ref_d   = ref_q;
        if (lookup_en) begin
            if (hit) begin
                ref_d[idx] = ref_after;
            end else if (!collide) begin
                valid_d[idx] = 1'b1;
                tag_d[idx]   = digest;
                ref_d[idx]   = REF_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                valid_q[i] <= 1'b0;
                tag_q[i]   <= '0;
                ref_q[i]   <= '0;
            end
        end else begin
            valid_q <= valid_d;
            tag_q   <= tag_d;
            ref_q   <= ref_d;
        end
    end

    // R4 / R7: a hit never reports a zero count (no wrap to zero)
    a_r7_hit_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_en && hit) |-> (ref_after != '0));

endmodule

// File: rtl/dedup_router.sv
module dedup_router
    import dedup_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int NODE_W = 2
) (
    input  logic [DIGEST_W-1:0] digest,
    output logic [NODE_W-1:0]   node,
    output logic [NODES-1:0]    sel
);

    always_comb begin
        node = NODE_W'(digest % DIGEST_W'(NODES));
    end

    for (genvar n = 0; n < NODES; n++) begin : g_sel
        assign sel[n] = (node == NODE_W'(n));
    end

endmodule

// File: rtl/dedup_engine.sv
module dedup_engine
    import dedup_pkg::*;
#(
    parameter int CHUNK_WORDS = 1024,
    parameter int IDX_W       = 10,
    parameter int REF_W       = 8,
    parameter int NODES       = 4,
    localparam int NODE_W     = (NODES > 1) ? $clog2(NODES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [DIGEST_W-1:0] in_data,
    output logic                res_valid,
    output logic                res_dup,
    output logic                res_overflow,
    output logic [IDX_W-1:0]    res_index,
    output logic [REF_W-1:0]    res_refcnt,
    output logic [NODE_W-1:0]   res_node,
    output logic [DIGEST_W-1:0] res_digest,
    output logic [NODES-1:0]    node_sel
);

    localparam int CNT_W = (CHUNK_WORDS > 1) ? $clog2(CHUNK_WORDS) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CHUNK_WORDS - 1);

    typedef struct packed {
        eng_state_e          st;
        logic [CNT_W-1:0]    wcnt;
        logic [DIGEST_W-1:0] digest;
        logic                rv;
        logic                rdup;
        logic                rovf;
        logic [IDX_W-1:0]    ridx;
        logic [REF_W-1:0]    rref;
        logic [NODE_W-1:0]   rnode;
        logic [DIGEST_W-1:0] rdig;
        logic [NODES-1:0]    rsel;
    } eng_regs_t;

    eng_regs_t r_d, r_q;

    logic                take, first, last;
    logic [DIGEST_W-1:0] crc_next;
    logic                t_hit, t_coll;
    logic [REF_W-1:0]    t_ref;
    logic [NODE_W-1:0]   rt_node;
    logic [NODES-1:0]    rt_sel;

    assign in_ready = (r_q.st == ST_ACCUM);
    assign take     = in_valid && in_ready;
    assign first    = (r_q.wcnt == '0);
    assign last     = (r_q.wcnt == LAST_CNT);

    dedup_crc_acc u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .first    (first),
        .word     (in_data),
        .crc_next (crc_next)
    );

    dedup_table #(.IDX_W(IDX_W), .REF_W(REF_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .lookup_en (r_q.st == ST_LOOKUP),
        .digest    (r_q.digest),
        .hit       (t_hit),
        .collide   (t_coll),
        .ref_after (t_ref)
    );

    dedup_router #(.NODES(NODES), .NODE_W(NODE_W)) u_router (
        .digest (r_q.digest),
        .node   (rt_node),
        .sel    (rt_sel)
    );

    always_comb begin
        r_d      = r_q;
        r_d.rv   = 1'b0;
        r_d.rovf = 1'b0;
        r_d.rsel = '0;
        case (r_q.st)
            ST_ACCUM: begin
                if (take) begin
                    if (last) begin
                        r_d.wcnt   = '0;
                        r_d.digest = crc_next;
                        r_d.st     = ST_LOOKUP;
                    end else begin
                        r_d.wcnt = r_q.wcnt + 1'b1;
                    end
                end
            end
            default: begin
                r_d.st    = ST_ACCUM;
                r_d.rv    = 1'b1;
                r_d.rdup  = t_hit;
                r_d.rovf  = t_coll;
                r_d.ridx  = r_q.digest[IDX_W-1:0];
                r_d.rref  = t_ref;
                r_d.rnode = rt_node;
                r_d.rdig  = r_q.digest;
                r_d.rsel  = t_hit ? '0 : rt_sel;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_ACCUM;
        end else begin
            r_q <= r_d;
        end
    end

    assign res_valid    = r_q.rv;
    assign res_dup      = r_q.rdup;
    assign res_overflow = r_q.rovf;
    assign res_index    = r_q.ridx;
    assign res_refcnt   = r_q.rref;
    assign res_node     = r_q.rnode;
    assign res_digest   = r_q.rdig;
    assign node_sel     = r_q.rsel;

    // R1: one result per chunk, a single-cycle pulse
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    // R1: the engine is ready again when the result appears
    a_r1_ready_with_result: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> in_ready);
    // R5: a duplicate selects no node
    a_r5_dup_no_node: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_dup) |-> (node_sel == '0));
    // R6: a new chunk selects exactly one node
    a_r6_new_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_dup) |-> ($countones(node_sel) == 1));
    // R8: overflow only flags a new chunk with a zero count
    a_r8_overflow_is_new: assert property (@(posedge clk) disable iff (!rst_n)
        res_overflow |-> (res_valid && !res_dup && res_refcnt == '0));
    // R9: node selects only appear with a result
    a_r9_sel_needs_result: assert property (@(posedge clk) disable iff (!rst_n)
        (node_sel != '0) |-> res_valid);

endmodule

// File: tb/tb_dedup_engine.sv
module tb_dedup_engine;

    localparam int CW    = 8;
    localparam int IDX_W = 4;
    localparam int REF_W = 3;
    localparam int NODES = 3;
    localparam int NODE_W = 2;
    localparam int ENT   = 1 << IDX_W;

    typedef logic [31:0] chunk_t [CW];

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic in_ready, res_valid, res_dup, res_overflow;
    logic [IDX_W-1:0] res_index;
    logic [REF_W-1:0] res_refcnt;
    logic [NODE_W-1:0] res_node;
    logic [31:0] res_digest;
    logic [NODES-1:0] node_sel;

    int checks = 0;
    int fails  = 0;

    // bench-side table model
    bit          m_v   [ENT];
    logic [31:0] m_tag [ENT];
    int          m_ref [ENT];

    always #10 clk = ~clk;   // 50 MHz

    dedup_engine #(.CHUNK_WORDS(CW), .IDX_W(IDX_W), .REF_W(REF_W), .NODES(NODES)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .res_valid(res_valid), .res_dup(res_dup), .res_overflow(res_overflow),
        .res_index(res_index), .res_refcnt(res_refcnt), .res_node(res_node),
        .res_digest(res_digest), .node_sel(node_sel)
    );

    function automatic logic [31:0] ref_crc(input chunk_t c);
        logic [31:0] r = 32'hFFFF_FFFF;
        for (int i = 0; i < CW; i++) begin
            for (int b = 31; b >= 0; b--) begin
                logic top = r[31] ^ c[i][b];
                r = r << 1;
                if (top) r = r ^ 32'h04C1_1DB7;
            end
        end
        return r;
    endfunction

    function automatic chunk_t make_chunk(input int seed);
        chunk_t c;
        for (int i = 0; i < CW; i++)
            c[i] = (seed * 32'h9E37_79B1) ^ (i * 32'h0101_0101) ^ (seed << 7);
        return c;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // send one chunk, model it, check every result field
    task automatic send_chunk(input chunk_t c, input int gap);
        logic [31:0] dig;
        int idx, eref, enode;
        bit edup, eovf;
        for (int i = 0; i < CW; i++) begin
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_data  = 32'hDEAD_BEEF;
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = c[i];
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk(in_ready == 1'b0, "R1", "ready low during lookup", 32'(in_ready), 32'd0);
        chk(res_valid == 1'b0, "R1", "no early result", 32'(res_valid), 32'd0);

        dig   = ref_crc(c);
        idx   = int'(dig[IDX_W-1:0]);
        enode = int'(dig % NODES);
        eovf  = 1'b0;
        if (m_v[idx] && m_tag[idx] == dig) begin
            edup = 1'b1;
            if (m_ref[idx] < (1 << REF_W) - 1) m_ref[idx]++;
            eref = m_ref[idx];
        end else if (m_v[idx]) begin
            edup = 1'b0; eovf = 1'b1; eref = 0;
        end else begin
            edup = 1'b0; eref = 1;
            m_v[idx] = 1'b1; m_tag[idx] = dig; m_ref[idx] = 1;
        end

        @(negedge clk);
        chk(res_valid == 1'b1, "R1", "result pulse", 32'(res_valid), 32'd1);
        chk(res_digest == dig, "R2", "digest", res_digest, dig);
        chk(int'(res_index) == idx, "R3", "slot index", 32'(res_index), 32'(idx));
        chk(res_dup == edup, "R4", "dup flag", 32'(res_dup), 32'(edup));
        chk(int'(res_refcnt) == eref, "R7", "ref count", 32'(res_refcnt), 32'(eref));
        chk(res_overflow == eovf, "R8", "overflow flag", 32'(res_overflow), 32'(eovf));
        if (edup) begin
            chk(node_sel == '0, "R5", "no node on dup", 32'(node_sel), 32'd0);
        end else begin
            chk(int'(res_node) == enode, "R6", "node", 32'(res_node), 32'(enode));
            chk(node_sel == NODES'(1 << enode), "R6", "node select", 32'(node_sel), 32'(1 << enode));
        end
        @(negedge clk);
        chk(res_valid == 1'b0, "R1", "pulse one cycle", 32'(res_valid), 32'd0);
        chk(in_ready == 1'b1, "R1", "ready again", 32'(in_ready), 32'd1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(in_ready == 1'b1, "R9", "ready after reset", 32'(in_ready), 32'd1);
        chk(res_valid == 1'b0, "R9", "no result after reset", 32'(res_valid), 32'd0);
        chk(node_sel == '0, "R9", "no select after reset", 32'(node_sel), 32'd0);
    endtask

    task automatic t_new_chunks();   // R6, R9: first chunks are new
        for (int s = 1; s <= 4; s++) send_chunk(make_chunk(s), 0);
    endtask

    task automatic t_duplicate();    // R4, R5
        send_chunk(make_chunk(1), 0);
        send_chunk(make_chunk(1), 0);
    endtask

    task automatic t_stall();        // R10
        send_chunk(make_chunk(2), 2);
        send_chunk(make_chunk(50), 1);
    endtask

    task automatic t_saturate();     // R7
        for (int k = 0; k < 10; k++) send_chunk(make_chunk(3), 0);
    endtask

    task automatic t_collision();    // R8
        logic [31:0] base = ref_crc(make_chunk(1));
        int found = -1;
        for (int s = 1000; s < 20000 && found < 0; s++) begin
            logic [31:0] d = ref_crc(make_chunk(s));
            if (d[IDX_W-1:0] == base[IDX_W-1:0] && d != base) found = s;
        end
        chk(found >= 0, "R8", "colliding chunk found", 32'(found), 32'd0);
        if (found >= 0) begin
            send_chunk(make_chunk(found), 0);
            send_chunk(make_chunk(1), 0);  // resident entry kept, count continues
        end
    endtask

    task automatic t_spread();       // R6 placement over many chunks
        for (int s = 200; s < 224; s++) send_chunk(make_chunk(s), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < ENT; i++) begin
            m_v[i] = 1'b0; m_tag[i] = '0; m_ref[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_new_chunks();
        t_duplicate();
        t_stall();
        t_saturate();
        t_collision();
        t_spread();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule